// File: doc/BRIEF.md
# Power-On Wake Controller

This block sits in the always-on domain of a battery-powered system and decides when the system leaves standby. It watches four raw wake inputs: battery insertion, a push button, a wall-adapter charger input and a USB power input. Each input passes a synchronizer and a debounce filter. A filtered rising edge arms that source. In standby, an armed source that is eligible starts a power-up: the controller raises the power enable and gives a one-cycle start request to the power-up sequencer. Charger, button and battery insertion are always eligible. USB is eligible only while the synchronized low-battery flag is clear.

After the start request, the host must confirm the power-up within a fixed window of millisecond ticks. It can do this by writing the acknowledge bit of the status register or by raising the acknowledge pin. Without confirmation, power is dropped and the block returns to standby. While power is on, the host can clear the acknowledge bit to turn the system off. The status register also records which source or sources caused the current wake-up.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: A raw wake input counts only after its synchronized value has differed from the filtered value on DEGLITCH_TICKS (default 32) consecutive ticks. A shorter pulse causes no wake-up.
- R2: A filtered charger rise (wake_raw bit 1) wakes the block whether the low-battery flag is high or low.
- R3: A filtered USB rise (wake_raw bit 0) wakes the block only while the low-battery flag is low. If USB stays present, the wake-up is deferred until the flag drops.
- R4: Battery insertion (bit 3) and the push button (bit 2) wake the block unconditionally.
- R5: A wake-up raises pwr_en and pulses seq_start high for exactly one cycle, in the cycle pwr_en rises.
- R6: During the acknowledge window, a write with data bit 4 = 1 to STATUS_ADDR or a high ack_pin_raw keeps power on, and status bit 4 then reads 1.
- R7: If no acknowledgement arrives by the ACK_TICKS-th tick (default 128) counted from the seq_start cycle, pwr_en drops and all status bits clear.
- R8: While powered, a write to STATUS_ADDR with bit 4 = 0 drops pwr_en, clears the status and returns the block to standby.
- R9: Reading STATUS_ADDR returns {3'b000, ack, battery, button, charger, usb} in bits 7..0. Any other address reads 0.
- R10: Every source that wakes in the same cycle gets its flag set. Sources that become valid while powered change no flag and are discarded.
- R11: Written values in bits 7..5 and 3..0 are ignored. In standby, a write of bit 4 = 1 has no effect.
- R12: If an acknowledge write lands in the same cycle as the window's final tick, the acknowledgement wins and power stays on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle millisecond tick enable |
| wake_raw | input | 4 | Raw wake inputs: [3] battery, [2] button, [1] charger, [0] USB |
| bat_low_raw | input | 1 | Low-battery comparator flag, asynchronous |
| ack_pin_raw | input | 1 | Host acknowledge pin, asynchronous |
| reg_addr | input | ADDR_W | Register address |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| seq_start | output | 1 | One-cycle power-up sequencer start |
| pwr_en | output | 1 | Power enable |

## Verification
Two pairs of events can fall in the same cycle. The first pair is the last tick of the acknowledge window and an acknowledge write. The bench provokes this by driving the write strobe and the 128th tick on the same clock edge. It then judges the result from pwr_en and status bit 4, which must show the acknowledgement won. The second pair is two sources passing their debounce filters together. The bench raises battery insertion and the charger on the same edge and expects both flags in the status read, with a single seq_start pulse.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;
    localparam int SRC_N    = 4;
    localparam int SRC_USB  = 0;
    localparam int SRC_CHG  = 1;
    localparam int SRC_BTN  = 2;
    localparam int SRC_BAT  = 3;
    localparam int ACK_BIT  = 4;
    localparam int DATA_W   = 8;
    localparam int STAT_W   = 5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_ON   = 2'd2
    } pw_state_e;
endpackage

// File: rtl/pwr_wake_sync.sv
module pwr_wake_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
        end
    end

    assign dout = sync_q;
endmodule

// File: rtl/pwr_wake_filter.sv
module pwr_wake_filter #(
    parameter int HOLD_TICKS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic din,
    output logic level,
    output logic rise
);
    localparam int CW = $clog2(HOLD_TICKS + 1);

    typedef struct packed {
        logic          level;
        logic          rise;
        logic [CW-1:0] cnt;
    } filt_s;

    filt_s flt_d, flt_q;

    always_comb begin
        flt_d      = flt_q;
        flt_d.rise = 1'b0;
        if (din == flt_q.level) begin
            flt_d.cnt = '0;
        end else if (tick) begin
            if (flt_q.cnt == CW'(HOLD_TICKS - 1)) begin
                flt_d.level = din;
                flt_d.cnt   = '0;
                flt_d.rise  = din;
            end else begin
                flt_d.cnt = flt_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flt_q <= '0;
        else        flt_q <= flt_d;
    end

    assign level = flt_q.level;
    assign rise  = flt_q.rise;
endmodule

// File: rtl/pwr_wake_fsm.sv
module pwr_wake_fsm
    import pwr_wake_pkg::*;
#(
    parameter int ACK_TICKS = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [SRC_N-1:0]  src_level,
    input  logic [SRC_N-1:0]  src_rise,
    input  logic              bat_low,
    input  logic              ack_pin,
    input  logic              wr_hit,
    input  logic              wr_ack,
    output logic              seq_start,
    output logic              pwr_en,
    output logic [STAT_W-1:0] status
);
    localparam int AW = $clog2(ACK_TICKS + 1);

    typedef struct packed {
        pw_state_e        state;
        logic [SRC_N-1:0] arm;
        logic [SRC_N-1:0] flags;
        logic [AW-1:0]    cnt;
        logic             seq;
    } ctl_s;

    ctl_s ctl_d, ctl_q;
    logic [SRC_N-1:0] elig;
    logic [SRC_N-1:0] wake;

    always_comb begin
        elig          = '1;
        elig[SRC_USB] = ~bat_low;
        wake          = ctl_q.arm & elig;

        ctl_d     = ctl_q;
        ctl_d.seq = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                ctl_d.arm = (ctl_q.arm | src_rise) & src_level;
                if (|wake) begin
                    ctl_d.state = ST_WAIT;
                    ctl_d.flags = wake;
                    ctl_d.cnt   = '0;
                    ctl_d.seq   = 1'b1;
                    ctl_d.arm   = '0;
                end
            end
            ST_WAIT: begin
                ctl_d.arm = '0;
                if (ack_pin || (wr_hit && wr_ack)) begin
                    ctl_d.state = ST_ON;
                end else if (wr_hit) begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.flags = '0;
                end else if (tick) begin
                    if (ctl_q.cnt == AW'(ACK_TICKS - 1)) begin
                        ctl_d.state = ST_IDLE;
                        ctl_d.flags = '0;
                        ctl_d.cnt   = '0;
                    end else begin
                        ctl_d.cnt = ctl_q.cnt + 1'b1;
                    end
                end
            end
            ST_ON: begin
                ctl_d.arm = '0;
                if (wr_hit && !wr_ack) begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.flags = '0;
                end
            end
            default: begin
                ctl_d.state = ST_IDLE;
                ctl_d.flags = '0;
                ctl_d.arm   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{state: ST_IDLE, default: '0};
        else        ctl_q <= ctl_d;
    end

    assign seq_start = ctl_q.seq;
    assign pwr_en    = (ctl_q.state != ST_IDLE);
    assign status    = {(ctl_q.state == ST_ON), ctl_q.flags};
endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
    import pwr_wake_pkg::*;
#(
    parameter int                DEGLITCH_TICKS = 32,
    parameter int                ACK_TICKS      = 128,
    parameter int                ADDR_W         = 4,
    parameter logic [ADDR_W-1:0] STATUS_ADDR    = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_ms,
    input  logic [3:0]        wake_raw,
    input  logic              bat_low_raw,
    input  logic              ack_pin_raw,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr_en,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              seq_start,
    output logic              pwr_en
);
    localparam int SYNC_W = SRC_N + 2;

    logic [SYNC_W-1:0] sync_out;
    logic [SRC_N-1:0]  src_level;
    logic [SRC_N-1:0]  src_rise;
    logic [STAT_W-1:0] status_w;
    logic              addr_hit;
    logic              unused_wdata;

    pwr_wake_sync #(.W(SYNC_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({ack_pin_raw, bat_low_raw, wake_raw}),
        .dout  (sync_out)
    );

    for (genvar g = 0; g < SRC_N; g++) begin : g_filt
        pwr_wake_filter #(.HOLD_TICKS(DEGLITCH_TICKS)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick_ms),
            .din   (sync_out[g]),
            .level (src_level[g]),
            .rise  (src_rise[g])
        );
    end

    assign addr_hit     = (reg_addr == STATUS_ADDR);
    assign unused_wdata = ^{reg_wdata[7:ACK_BIT+1], reg_wdata[ACK_BIT-1:0]};

    pwr_wake_fsm #(.ACK_TICKS(ACK_TICKS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_ms),
        .src_level (src_level),
        .src_rise  (src_rise),
        .bat_low   (sync_out[SRC_N]),
        .ack_pin   (sync_out[SRC_N+1]),
        .wr_hit    (reg_wr_en && addr_hit),
        .wr_ack    (reg_wdata[ACK_BIT]),
        .seq_start (seq_start),
        .pwr_en    (pwr_en),
        .status    (status_w)
    );

    always_comb begin
        reg_rdata = '0;
        if (addr_hit) reg_rdata[STAT_W-1:0] = status_w;
    end
endmodule

// File: rtl/pwr_wake_ctrl_chk.sv
module pwr_wake_ctrl_chk #(
    parameter int ACK_TICKS = 128
) (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_ms,
    input logic [7:0] reg_rdata,
    input logic       seq_start,
    input logic       pwr_en,
    input logic [4:0] status
);
    localparam int CW = $clog2(ACK_TICKS + 2);

    logic [CW-1:0] win_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               win_cnt <= '0;
        else if (seq_start)                       win_cnt <= CW'(tick_ms);
        else if (pwr_en && !status[4] && tick_ms) win_cnt <= win_cnt + 1'b1;
    end

    // R5
    seq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |=> !seq_start);

    // R5
    seq_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |-> pwr_en);

    // R5
    power_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_en) |-> seq_start);

    // R9
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[7:5] == 3'b000);

    // R7
    off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |-> (status == 5'd0));

    // R10
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_en && !seq_start) |-> $stable(status[3:0]));

    // R7
    ack_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_en && !status[4] && !seq_start) |-> (win_cnt < CW'(ACK_TICKS)));
endmodule

bind pwr_wake_ctrl pwr_wake_ctrl_chk #(.ACK_TICKS(ACK_TICKS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_ms   (tick_ms),
    .reg_rdata (reg_rdata),
    .seq_start (seq_start),
    .pwr_en    (pwr_en),
    .status    (status_w)
);

// File: tb/pwr_wake_ctrl_test.sv
module pwr_wake_ctrl_test;
    localparam int DG  = 32;
    localparam int ACK = 128;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_ms = 1'b0;
    logic [3:0] wake_raw = '0;
    logic       bat_low_raw = 1'b0;
    logic       ack_pin_raw = 1'b0;
    logic [3:0] reg_addr = '0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       seq_start;
    logic       pwr_en;

    int checks = 0;
    int failures = 0;
    int seq_cnt = 0;

    always #5 clk = ~clk;

    pwr_wake_ctrl uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_ms     (tick_ms),
        .wake_raw    (wake_raw),
        .bat_low_raw (bat_low_raw),
        .ack_pin_raw (ack_pin_raw),
        .reg_addr    (reg_addr),
        .reg_wr_en   (reg_wr_en),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .seq_start   (seq_start),
        .pwr_en      (pwr_en)
    );

    always @(negedge clk) if (rst_n && seq_start) seq_cnt++;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick_ms = 1'b1;
            @(negedge clk) tick_ms = 1'b0;
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
        reg_addr = '0;
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        reg_addr  = '0;
        reg_wdata = d;
        reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic raise(input logic [3:0] m);
        wake_raw = wake_raw | m;
        idle(3);
        tick_n(DG);
        idle(5);
    endtask

    task automatic settle();
        wake_raw = '0;
        idle(3);
        tick_n(DG + 1);
        idle(3);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(4'd0, v);
        chk(v == 8'h00, "R9 reset status", v, 8'h00);
        chk(!pwr_en && !seq_start, "R5 reset outputs", {pwr_en, seq_start}, 0);
    endtask

    task automatic t_glitch();
        wake_raw[1] = 1'b1;
        idle(3);
        tick_n(DG - 1);
        wake_raw[1] = 1'b0;
        idle(3);
        tick_n(4);
        idle(4);
        chk(!pwr_en, "R1 short pulse ignored", pwr_en, 0);
        wake_raw[1] = 1'b1;
        idle(3);
        tick_n(DG - 1);
        idle(5);
        chk(!pwr_en, "R1 not valid before full hold", pwr_en, 0);
        tick_n(1);
        idle(5);
        chk(pwr_en, "R1 valid after full hold", pwr_en, 1);
        wr(8'h00);
        settle();
    endtask

    task automatic t_charger();
        logic [7:0] v;
        int s0;
        bat_low_raw = 1'b1;
        s0 = seq_cnt;
        raise(4'b0010);
        chk(pwr_en, "R2 charger wakes on low battery", pwr_en, 1);
        chk(seq_cnt == s0 + 1, "R5 single seq_start", seq_cnt - s0, 1);
        rd(4'd0, v);
        chk(v == 8'h02, "R9 charger flag", v, 8'h02);
        wr(8'h10);
        rd(4'd0, v);
        chk(v == 8'h12, "R6 ack by write", v, 8'h12);
        rd(4'd5, v);
        chk(v == 8'h00, "R9 other address reads zero", v, 8'h00);
        wr(8'h00);
        idle(1);
        rd(4'd0, v);
        chk(!pwr_en && v == 8'h00, "R8 power off by write", {pwr_en, v}, 0);
        settle();
    endtask

    task automatic t_usb();
        logic [7:0] v;
        bat_low_raw = 1'b1;
        idle(4);
        raise(4'b0001);
        tick_n(8);
        idle(3);
        chk(!pwr_en, "R3 usb blocked on low battery", pwr_en, 0);
        bat_low_raw = 1'b0;
        idle(6);
        chk(pwr_en, "R3 usb wakes after battery recovers", pwr_en, 1);
        rd(4'd0, v);
        chk(v == 8'h01, "R9 usb flag", v, 8'h01);
        ack_pin_raw = 1'b1;
        idle(4);
        ack_pin_raw = 1'b0;
        rd(4'd0, v);
        chk(v == 8'h11, "R6 ack by pin", v, 8'h11);
        wr(8'hFF);
        rd(4'd0, v);
        chk(v == 8'h11 && pwr_en, "R11 flag bits not writable", v, 8'h11);
        wr(8'h00);
        settle();
    endtask

    task automatic t_timeout();
        logic [7:0] v;
        raise(4'b0100);
        rd(4'd0, v);
        chk(v == 8'h04, "R4 button wakes", v, 8'h04);
        tick_n(ACK - 1);
        idle(2);
        chk(pwr_en, "R7 still on before window end", pwr_en, 1);
        tick_n(1);
        idle(2);
        rd(4'd0, v);
        chk(!pwr_en && v == 8'h00, "R7 timeout drops power", {pwr_en, v}, 0);
        settle();
    endtask

    task automatic t_multi();
        logic [7:0] v;
        int s0;
        s0 = seq_cnt;
        raise(4'b1010);
        rd(4'd0, v);
        chk(v == 8'h0A, "R10 simultaneous flags", v, 8'h0A);
        chk(seq_cnt == s0 + 1, "R5 one pulse for two sources", seq_cnt - s0, 1);
        wr(8'h10);
        raise(4'b0100);
        rd(4'd0, v);
        chk(v == 8'h1A, "R10 event while on ignored", v, 8'h1A);
        wr(8'h00);
        idle(3);
        tick_n(5);
        idle(3);
        chk(!pwr_en, "R10 discarded event no rewake", pwr_en, 0);
        settle();
    endtask

    task automatic t_race();
        logic [7:0] v;
        raise(4'b1000);
        tick_n(ACK - 1);
        @(negedge clk);
        tick_ms   = 1'b1;
        reg_addr  = '0;
        reg_wdata = 8'h10;
        reg_wr_en = 1'b1;
        @(negedge clk);
        tick_ms   = 1'b0;
        reg_wr_en = 1'b0;
        idle(2);
        rd(4'd0, v);
        chk(pwr_en && v == 8'h18, "R12 ack wins over last tick", v, 8'h18);
        wr(8'h00);
        settle();
    endtask

    task automatic t_standby_write();
        logic [7:0] v;
        int s0;
        s0 = seq_cnt;
        wr(8'hFF);
        idle(3);
        rd(4'd0, v);
        chk(v == 8'h00 && !pwr_en, "R11 standby write ignored", v, 8'h00);
        chk(seq_cnt == s0, "R11 no start from write", seq_cnt - s0, 0);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_glitch();
        t_charger();
        t_usb();
        t_timeout();
        t_multi();
        t_race();
        t_standby_write();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule